// File: doc/BRIEF.md
# Real-Time Clock Compare Channel

This block is a single alarm channel of a real-time clock. Software stores a 32-bit alarm time through a small write-only register port in a fast bus clock domain. The upper half of that time is whole seconds and the lower half is a binary fraction in steps of 1/65536 s, so 0x0005_8000 means 5.5 s after the clock started. The block compares the alarm time against the running time, which is built from the low 16 bits of an external seconds counter and the upper 16 bits of an external subsecond counter. The running time is sampled in the slow timekeeping clock domain.

A match means the running time has reached or passed the alarm time. It is computed as a modular 32-bit difference, so the comparison still works when the seconds field wraps. A new alarm time that lies up to one second behind the current time therefore matches at once. Each alarm value produces one single-cycle event pulse and sets a sticky flag. Software clears the flag by writing one to it, and a channel enable gates the whole event path.

Bus writes reach the slow domain through a toggle request and acknowledge handshake. While a transfer is in flight the block reports busy and drops any further writes.

Top module: `rtc_cmp_channel`

## Requirements
- R1: After reset, wr_busy, evt_pulse and evt_flag are 0, the alarm value is 0 and the channel is disabled, so no event occurs with time at 0.
- R2: A write with wr_addr 0 loads wr_data as the alarm value, with bits 31:16 as seconds and bits 15:0 as fraction. The running time is {sec_count, subsec_hi}, so 0x0005_8000 matches at sec_count 5 and subsec_hi 0x8000.
- R3: While enabled and armed, a running time T with (T - alarm) mod 2^32 < 0x0001_0000 raises evt_pulse for one slow cycle and sets evt_flag. The pulse appears on the slow edge after T is presented.
- R4: No event occurs while (T - alarm) mod 2^32 is 0x0001_0000 or more, for times before the alarm and times more than one second past it.
- R5: Writing an alarm value in the range (T - 0x0001_0000, T] fires the event right after the transfer. Values at T - 0x0001_0000 or later than T do not fire.
- R6: An alarm value fires once: evt_pulse does not repeat while the match condition keeps holding.
- R7: evt_flag is sticky. It rises only together with evt_pulse, and it is cleared by a write with wr_addr 2 and wr_data bit 0 set. A write of 0 there leaves it unchanged.
- R8: After a fire, the channel re-arms when a new alarm value is written, or when the flag is clear and the match condition no longer holds. Clearing the flag while the match still holds does not fire again.
- R9: A write with wr_addr 1 sets the enable from wr_data bit 0. While disabled, no pulse occurs and the flag does not set, but the channel stays armed. Enabling while the match holds fires.
- R10: wr_busy rises the bus cycle after an accepted write and falls once the slow domain has acknowledged. Writes made while busy are dropped, and the held command stays stable while busy.
- R11: The comparison wraps. With alarm 0xFFFF_F000 and time 0x0000_0100, the event fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register port clock |
| bus_rst_n | input | 1 | Active-low asynchronous reset, bus domain |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | 0 alarm value, 1 enable, 2 flag clear, 3 unused |
| wr_data | input | 32 | Write data |
| wr_busy | output | 1 | Transfer into slow domain in flight |
| slow_clk | input | 1 | Timekeeping clock |
| slow_rst_n | input | 1 | Active-low asynchronous reset, slow domain |
| sec_count | input | 16 | Low 16 bits of the seconds counter |
| subsec_hi | input | 16 | Upper 16 bits of the subsecond counter |
| evt_pulse | output | 1 | One-cycle channel event, slow domain |
| evt_flag | output | 1 | Sticky event flag, slow domain |

## Verification
A corrupted alarm register or a wrong modular difference shows up at the slow edge right after the next time change. The pulse then appears at an offset where it should not, or is missing at one of the window boundaries, and the bench sweeps those offsets around several alarm values, including a wrapped one. A stuck or wrongly updated arming state shows as repeated pulses while time sits in the window, or as a missing pulse after the flag is cleared and time re-enters. Either shows within a few slow cycles. A broken handshake shows as busy never falling, which the wait loops turn into a timeout, or as an alarm value that is never applied.

// File: rtl/rtc_cmp_pkg.sv
package rtc_cmp_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    CMD_ALARM = 2'd0,
    CMD_CTRL  = 2'd1,
    CMD_CLEAR = 2'd2,
    CMD_NONE  = 2'd3
  } cmd_kind_e;

  typedef struct packed {
    cmd_kind_e          kind;
    logic [DATA_W-1:0]  data;
  } cmd_t;
endpackage

// File: rtl/rtc_cdc_sync.sv
module rtc_cdc_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_d;

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/rtc_cmp_bus_side.sv
module rtc_cmp_bus_side
  import rtc_cmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ack_sync,
  output logic              req_tgl,
  output cmd_t              hold,
  output logic              busy
);
  logic req_q, req_d;
  cmd_t hold_q, hold_d;
  logic accept;

  assign busy   = req_q ^ ack_sync;
  assign accept = wr_en & ~busy & (wr_addr != CMD_NONE);

  always_comb begin
    req_d  = req_q;
    hold_d = hold_q;
    if (accept) begin
      req_d       = ~req_q;
      hold_d.kind = cmd_kind_e'(wr_addr);
      hold_d.data = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      req_q  <= req_d;
      hold_q <= hold_d;
    end
  end

  assign req_tgl = req_q;
  assign hold    = hold_q;
endmodule

// File: rtl/rtc_cmp_core.sv
module rtc_cmp_core
  import rtc_cmp_pkg::*;
#(
  parameter int SEC_W  = 16,
  parameter int FRAC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEC_W-1:0] sec_count,
  input  logic [FRAC_W-1:0] subsec_hi,
  input  logic             req_sync,
  input  cmd_t             cmd,
  output logic             ack_tgl,
  output logic             evt_pulse,
  output logic             evt_flag
);
  localparam int TIME_W = SEC_W + FRAC_W;
  localparam logic [TIME_W-1:0] WINDOW = {{(TIME_W-1){1'b0}}, 1'b1} << FRAC_W;

  logic [TIME_W-1:0] alarm_q, alarm_d;
  logic [TIME_W-1:0] now_time, diff;
  logic enable_q, enable_d;
  logic armed_q, armed_d;
  logic flag_q, flag_d;
  logic pulse_q;
  logic ack_q;
  logic new_cmd, load_alarm, load_ctrl, clear_flag, hit, fire;

  assign now_time   = {sec_count, subsec_hi};
  assign diff       = now_time - alarm_q;
  assign hit        = diff < WINDOW;
  assign fire       = enable_q & armed_q & hit;

  assign new_cmd    = req_sync ^ ack_q;
  assign load_alarm = new_cmd & (cmd.kind == CMD_ALARM);
  assign load_ctrl  = new_cmd & (cmd.kind == CMD_CTRL);
  assign clear_flag = new_cmd & (cmd.kind == CMD_CLEAR) & cmd.data[0];

  always_comb begin
    alarm_d  = load_alarm ? cmd.data[TIME_W-1:0] : alarm_q;
    enable_d = load_ctrl  ? cmd.data[0]          : enable_q;

    if (load_alarm)          armed_d = 1'b1;
    else if (fire)           armed_d = 1'b0;
    else if (!flag_q && !hit) armed_d = 1'b1;
    else                     armed_d = armed_q;

    if (fire)            flag_d = 1'b1;
    else if (clear_flag) flag_d = 1'b0;
    else                 flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q  <= '0;
      enable_q <= 1'b0;
      armed_q  <= 1'b1;
      flag_q   <= 1'b0;
      pulse_q  <= 1'b0;
      ack_q    <= 1'b0;
    end else begin
      alarm_q  <= alarm_d;
      enable_q <= enable_d;
      armed_q  <= armed_d;
      flag_q   <= flag_d;
      pulse_q  <= fire;
      ack_q    <= req_sync;
    end
  end

  assign ack_tgl   = ack_q;
  assign evt_pulse = pulse_q;
  assign evt_flag  = flag_q;
endmodule

// File: rtl/rtc_cmp_channel.sv
module rtc_cmp_channel
  import rtc_cmp_pkg::*;
#(
  parameter int SEC_W       = 16,
  parameter int FRAC_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_busy,
  input  logic              slow_clk,
  input  logic              slow_rst_n,
  input  logic [SEC_W-1:0]  sec_count,
  input  logic [FRAC_W-1:0] subsec_hi,
  output logic              evt_pulse,
  output logic              evt_flag
);
  logic req_tgl, req_sync, ack_tgl, ack_sync;
  cmd_t hold;

  rtc_cmp_bus_side i_bus (
    .clk      (bus_clk),
    .rst_n    (bus_rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .ack_sync (ack_sync),
    .req_tgl  (req_tgl),
    .hold     (hold),
    .busy     (wr_busy)
  );

  rtc_cdc_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) i_req_sync (
    .clk   (slow_clk),
    .rst_n (slow_rst_n),
    .d     (req_tgl),
    .q     (req_sync)
  );

  rtc_cdc_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) i_ack_sync (
    .clk   (bus_clk),
    .rst_n (bus_rst_n),
    .d     (ack_tgl),
    .q     (ack_sync)
  );

  rtc_cmp_core #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) i_core (
    .clk       (slow_clk),
    .rst_n     (slow_rst_n),
    .sec_count (sec_count),
    .subsec_hi (subsec_hi),
    .req_sync  (req_sync),
    .cmd       (hold),
    .ack_tgl   (ack_tgl),
    .evt_pulse (evt_pulse),
    .evt_flag  (evt_flag)
  );
endmodule

// File: rtl/rtc_cmp_channel_chk.sv
module rtc_cmp_channel_chk #(
  parameter int TIME_W = 32,
  parameter int FRAC_W = 16,
  parameter int HOLD_W = 34
) (
  input logic              slow_clk,
  input logic              slow_rst_n,
  input logic              bus_clk,
  input logic              bus_rst_n,
  input logic              wr_en,
  input logic              wr_busy,
  input logic              evt_pulse,
  input logic              evt_flag,
  input logic [TIME_W-1:0] now_val,
  input logic [TIME_W-1:0] alarm_val,
  input logic              en_val,
  input logic [HOLD_W-1:0] hold_val
);
  localparam logic [TIME_W-1:0] WINDOW = {{(TIME_W-1){1'b0}}, 1'b1} << FRAC_W;

  assert_pulse_in_window_R3: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
    evt_pulse |-> (($past(now_val) - $past(alarm_val)) < WINDOW));

  assert_pulse_needs_enable_R9: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
    evt_pulse |-> $past(en_val));

  assert_flag_rise_with_pulse_R7: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
    $rose(evt_flag) |-> evt_pulse);

  assert_hold_stable_busy_R10: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (wr_busy && $past(wr_busy)) |-> $stable(hold_val));

  assert_busy_after_write_R10: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    $rose(wr_busy) |-> $past(wr_en));
endmodule

bind rtc_cmp_channel rtc_cmp_channel_chk #(
  .TIME_W (SEC_W + FRAC_W),
  .FRAC_W (FRAC_W),
  .HOLD_W ($bits(rtc_cmp_pkg::cmd_t))
) i_chk (
  .slow_clk   (slow_clk),
  .slow_rst_n (slow_rst_n),
  .bus_clk    (bus_clk),
  .bus_rst_n  (bus_rst_n),
  .wr_en      (wr_en),
  .wr_busy    (wr_busy),
  .evt_pulse  (evt_pulse),
  .evt_flag   (evt_flag),
  .now_val    (i_core.now_time),
  .alarm_val  (i_core.alarm_q),
  .en_val     (i_core.enable_q),
  .hold_val   (i_bus.hold_q)
);

// File: tb/test_rtc_cmp_channel.sv
module test_rtc_cmp_channel;
  logic        bus_clk = 1'b0;
  logic        slow_clk = 1'b0;
  logic        bus_rst_n = 1'b0;
  logic        slow_rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic        wr_busy;
  logic [15:0] sec_count = 16'd0;
  logic [15:0] subsec_hi = 16'd0;
  logic        evt_pulse, evt_flag;

  int n_checks = 0;
  int n_errors = 0;
  int pulse_cnt = 0;

  always #5ns  bus_clk  = ~bus_clk;
  always #20ns slow_clk = ~slow_clk;

  rtc_cmp_channel i_rtc_cmp_channel (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_busy(wr_busy), .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
    .sec_count(sec_count), .subsec_hi(subsec_hi), .evt_pulse(evt_pulse), .evt_flag(evt_flag)
  );

  always @(negedge slow_clk) if (slow_rst_n && evt_pulse) pulse_cnt++;

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge bus_clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge bus_clk);
    wr_en = 1'b0;
    while (wr_busy) @(negedge bus_clk);
    repeat (3) @(negedge slow_clk);
  endtask

  task automatic set_time(input logic [31:0] t);
    @(negedge slow_clk);
    sec_count = t[31:16];
    subsec_hi = t[15:0];
    repeat (3) @(negedge slow_clk);
  endtask

  initial begin
    #1ms;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int base;
    logic [31:0] alarms [4];
    logic [31:0] offs [10];
    alarms = '{32'h0000_0000, 32'h0005_8000, 32'h8000_0000, 32'hFFFF_F000};
    offs = '{32'h0, 32'h1, 32'hFFFF, 32'h1_0000, 32'h1_0001,
             32'hFFFF_FFFF, 32'hFFFF_0000, 32'h8000, 32'h7FFF_FFFF, 32'h100};

    repeat (3) @(negedge bus_clk);
    bus_rst_n = 1'b1;
    @(negedge slow_clk);
    slow_rst_n = 1'b1;
    repeat (4) @(negedge slow_clk);

    // R1: reset state, disabled with alarm 0 and time 0
    chk("R1 busy", 32'(wr_busy), 0);
    chk("R1 flag", 32'(evt_flag), 0);
    chk("R1 pulse count", 32'(pulse_cnt), 0);

    // R9: enabling while match holds fires
    bus_write(2'd1, 32'd1);
    chk("R9 enable fires", 32'(pulse_cnt), 1);
    chk("R7 flag set", 32'(evt_flag), 1);

    // R6: no repeat while match holds
    repeat (10) @(negedge slow_clk);
    chk("R6 single pulse", 32'(pulse_cnt), 1);

    // R7: write 0 leaves flag, write 1 clears
    bus_write(2'd2, 32'd0);
    chk("R7 write0 keeps flag", 32'(evt_flag), 1);
    bus_write(2'd2, 32'd1);
    chk("R7 clear flag", 32'(evt_flag), 0);
    // R8: cleared while match holds, no refire
    chk("R8 no refire in window", 32'(pulse_cnt), 1);
    set_time(32'h0002_0000);
    set_time(32'h0000_0010);
    chk("R8 rearm after leave", 32'(pulse_cnt), 2);

    // R5: immediate fire on write into past window
    set_time(32'h0005_8100);
    base = pulse_cnt;
    bus_write(2'd0, 32'h0005_8000);
    chk("R5 past value fires", 32'(pulse_cnt - base), 1);
    bus_write(2'd0, 32'h0004_8101);
    chk("R5 oldest in window fires", 32'(pulse_cnt - base), 2);
    bus_write(2'd0, 32'h0004_8100);
    chk("R5 one second back silent", 32'(pulse_cnt - base), 2);
    bus_write(2'd0, 32'h0005_8101);
    chk("R5 future silent", 32'(pulse_cnt - base), 2);

    // R11: wrap
    set_time(32'hFFFF_0000);
    bus_write(2'd0, 32'hFFFF_F000);
    base = pulse_cnt;
    set_time(32'h0000_0100);
    chk("R11 wrap fires", 32'(pulse_cnt - base), 1);

    // R9: disabled, no pulse no flag
    bus_write(2'd2, 32'd1);
    bus_write(2'd1, 32'd0);
    base = pulse_cnt;
    bus_write(2'd0, 32'h0000_0080);
    chk("R9 disabled no pulse", 32'(pulse_cnt - base), 0);
    chk("R9 disabled no flag", 32'(evt_flag), 0);
    bus_write(2'd1, 32'd1);
    chk("R9 enable later fires", 32'(pulse_cnt - base), 1);

    // R10: write during busy dropped
    bus_write(2'd2, 32'd1);
    base = pulse_cnt;
    @(negedge bus_clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'h0100_0000;
    @(negedge bus_clk);
    chk("R10 busy after write", 32'(wr_busy), 1);
    wr_data = 32'h0000_0100;
    @(negedge bus_clk);
    wr_en = 1'b0;
    while (wr_busy) @(negedge bus_clk);
    repeat (4) @(negedge slow_clk);
    chk("R10 busy write dropped", 32'(pulse_cnt - base), 0);
    chk("R10 busy falls", 32'(wr_busy), 0);

    // R2 R3 R4: sweep offsets around several alarm values
    foreach (alarms[i]) begin
      foreach (offs[j]) begin
        logic exp_hit;
        exp_hit = offs[j] < 32'h0001_0000;
        set_time(alarms[i] - 32'h0002_0000);
        bus_write(2'd0, alarms[i]);
        bus_write(2'd2, 32'd1);
        base = pulse_cnt;
        set_time(alarms[i] + offs[j]);
        if (exp_hit) begin
          chk("R3 R2 hit pulse", 32'(pulse_cnt - base), 1);
          chk("R3 hit flag", 32'(evt_flag), 1);
        end else begin
          chk("R4 miss pulse", 32'(pulse_cnt - base), 0);
          chk("R4 miss flag", 32'(evt_flag), 0);
        end
      end
    end

    finish_run();
  end
endmodule